// File: doc/BRIEF.md
# Buck-Boost Burst Switch Sequencer

This block sequences the four power-switch enables of a buck-boost converter that runs in burst fashion. Switch A connects the input to the first inductor node, and B grounds that node. Switch D connects the second inductor node to the output, and C grounds it. The block consumes comparator results that are already digitised and synchronous to its clock. These are an output-below-regulation flag, a two-bit code for the input/output relation, inductor-current peak, valley and zero flags, an output-above-startup-level flag, a shutdown pin and an over-temperature flag.

While the output sits above regulation the block sleeps with every switch open. When the output drops, it runs charge/discharge pairs until the output recovers, then closes the burst with one discharge that runs down to zero current. Which pairs it uses depends on the mode code, which is latched at the start of every charge interval. Boost pairs are AC then AD. Four-switch pairs are AC, then a timed AD, then BD. Buck pairs are AD then BD. While the output is still below the startup level, a separate sequence applies: AC until peak, then B alone for a fixed time, with D never closed.

Each leg passes through a dead-time gap before the complementary switch closes. Shutdown and over-temperature open every switch in the same cycle.

Top module: `bb_burst_seq`

## Requirements
- R1: After reset, and whenever the sequencer is asleep (output-below-regulation flag low and no burst in progress), all four switch enables are low, and current flags have no effect.
- R2: The mode code is latched only when a charge interval starts: 2'b00 selects boost, 2'b10 selects buck, and 2'b01 or 2'b11 selects four-switch. A code change during a pair does not alter that pair.
- R3: In boost mode the pins show A+C until the peak flag, then A+D until the valley flag, repeating while the output is below regulation; B is never closed.
- R4: In four-switch mode the pins show A+C until the peak flag, then A+D for TOFF_CYC sequencer cycles, then B+D until the valley flag. TOFF_CYC is CLK_MHZ*TOFF_NS/1000, and the A+D interval is visible at the pins as TOFF_CYC-DEAD_CYC cycles.
- R5: In buck mode the pins show A+D until the peak flag, then B+D until the valley flag, repeating.
- R6: A discharge that begins after the output-below-regulation flag has dropped ends only on the zero-current flag, not on the valley flag, and is followed by sleep.
- R7: When a burst or pair starts with the startup flag low, the pins show A+C until the peak flag, then B alone for TSU_CYC cycles (CLK_MHZ*TSU_NS/1000), visible as TSU_CYC-DEAD_CYC cycles. D stays open throughout, and the valley and zero flags are ignored.
- R8: A and B are never high together, and C and D are never high together.
- R9: A switch never closes in the cycle right after its complement was closed; every changeover leaves DEAD_CYC cycles with both switches of the leg open.
- R10: Shutdown or over-temperature drives all four enables low in the same cycle. Once the flag clears, a new burst starts from sleep and uses the startup sequence if the startup flag is low.
- R11: From sleep, the first charge pair appears at the pins two clock edges after the output-below-regulation flag is raised, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vout_low | input | 1 | Output is below regulation |
| mode_code | input | 2 | Input/output relation: 00 boost, 01/11 four-switch, 10 buck |
| vout_up | input | 1 | Output is above the startup level |
| pk_hit | input | 1 | Inductor current reached peak |
| vly_hit | input | 1 | Inductor current fell to valley |
| zro_hit | input | 1 | Inductor current fell to zero |
| shdn | input | 1 | Shutdown request, active high |
| hot | input | 1 | Over-temperature, active high |
| sw_a | output | 1 | Enable for input-side high switch |
| sw_b | output | 1 | Enable for input-side low switch |
| sw_c | output | 1 | Enable for output-side low switch |
| sw_d | output | 1 | Enable for output-side high switch |

## Verification
A wrong sequencer state shows up at the switch pins within the dead-time window after the transition, at most DEAD_CYC+1 edges later. It appears as a wrong switch pair, a pair that outlasts its ending flag, or an early return to sleep. A wrong latched mode shows as the wrong pair in the first interval after the charge starts. A miscounted timer shows as an A+D or B-only window of the wrong length, which the bench measures exactly. A guard fault shows as an overlap or a missing gap on a leg in the very cycle it occurs.

// File: rtl/bb_burst_pkg.sv
package bb_burst_pkg;

    typedef enum logic [1:0] {
        ST_SLEEP,
        ST_CHARGE,
        ST_XFER,
        ST_DISCH
    } seq_state_e;

    typedef enum logic [1:0] {
        MD_BOOST,
        MD_FOUR,
        MD_BUCK,
        MD_START
    } pair_mode_e;

    typedef struct packed {
        logic a;
        logic b;
        logic c;
        logic d;
    } sw_set_t;

    typedef struct packed {
        seq_state_e st;
        pair_mode_e md;
    } seq_t;

    // Mode latched at each charge start; startup overrides the code.
    function automatic pair_mode_e pick_mode(input logic [1:0] code, input logic above_su);
        pair_mode_e m;
        if (!above_su)           m = MD_START;
        else if (code == 2'b00)  m = MD_BOOST;
        else if (code == 2'b10)  m = MD_BUCK;
        else                     m = MD_FOUR;
        return m;
    endfunction

endpackage

// File: rtl/bb_tick_timer.sv
module bb_tick_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)              cnt_d = load_val;
        else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/bb_leg_guard.sv
// One half-bridge leg: on[1] is the high switch, on[0] the low switch.
module bb_leg_guard #(
    parameter int DEAD = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       kill,
    input  logic [1:0] req,
    output logic [1:0] on
);
    localparam int DW = (DEAD < 2) ? 1 : $clog2(DEAD + 1);

    typedef struct packed {
        logic [1:0]    on;
        logic [DW-1:0] cnt;
    } leg_t;

    leg_t st_d, st_q;
    logic [1:0] req_s;

    always_comb begin
        req_s = (req == 2'b11) ? 2'b00 : req;
        st_d  = st_q;
        if (kill) begin
            st_d.on  = 2'b00;
            st_d.cnt = DW'(DEAD - 1);
        end else if (req_s != st_q.on) begin
            if (st_q.on != 2'b00) begin
                st_d.on  = 2'b00;
                st_d.cnt = DW'(DEAD - 1);
            end else if (st_q.cnt != '0) begin
                st_d.cnt = st_q.cnt - 1'b1;
            end else begin
                st_d.on = req_s;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign on = st_q.on;
endmodule

// File: rtl/bb_burst_seq.sv
module bb_burst_seq
    import bb_burst_pkg::*;
#(
    parameter int CLK_MHZ  = 250,
    parameter int TOFF_NS  = 3000,
    parameter int TSU_NS   = 800,
    parameter int DEAD_CYC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vout_low,
    input  logic [1:0] mode_code,
    input  logic       vout_up,
    input  logic       pk_hit,
    input  logic       vly_hit,
    input  logic       zro_hit,
    input  logic       shdn,
    input  logic       hot,
    output logic       sw_a,
    output logic       sw_b,
    output logic       sw_c,
    output logic       sw_d
);
    localparam int TOFF_CYC = CLK_MHZ * TOFF_NS / 1000;
    localparam int TSU_CYC  = CLK_MHZ * TSU_NS / 1000;
    localparam int TMAX     = (TOFF_CYC > TSU_CYC) ? TOFF_CYC : TSU_CYC;
    localparam int CW       = $clog2(TMAX + 1);
    localparam int NLEG     = 2;

    seq_t          cur_d, cur_q;
    sw_set_t       req;
    logic          kill;
    logic          t_load;
    logic [CW-1:0] t_val;
    logic          t_exp;
    logic          dis_end;
    logic [1:0]    leg_req [NLEG];
    logic [1:0]    leg_on  [NLEG];

    assign kill = shdn | hot;

    always_comb begin
        cur_d   = cur_q;
        req     = '0;
        t_load  = 1'b0;
        t_val   = '0;
        dis_end = 1'b0;
        case (cur_q.st)
            ST_SLEEP: begin
                if (vout_low) begin
                    cur_d.st = ST_CHARGE;
                    cur_d.md = pick_mode(mode_code, vout_up);
                end
            end
            ST_CHARGE: begin
                if (cur_q.md == MD_BUCK) begin req.a = 1'b1; req.d = 1'b1; end
                else                     begin req.a = 1'b1; req.c = 1'b1; end
                if (pk_hit) begin
                    if (cur_q.md == MD_FOUR) begin
                        cur_d.st = ST_XFER;
                        t_load   = 1'b1;
                        t_val    = CW'(TOFF_CYC - 1);
                    end else begin
                        cur_d.st = ST_DISCH;
                        if (cur_q.md == MD_START) begin
                            t_load = 1'b1;
                            t_val  = CW'(TSU_CYC - 1);
                        end
                    end
                end
            end
            ST_XFER: begin
                req.a = 1'b1;
                req.d = 1'b1;
                if (t_exp) cur_d.st = ST_DISCH;
            end
            default: begin
                case (cur_q.md)
                    MD_BOOST: begin req.a = 1'b1; req.d = 1'b1; end
                    MD_START: begin req.b = 1'b1; end
                    default:  begin req.b = 1'b1; req.d = 1'b1; end
                endcase
                if (cur_q.md == MD_START) dis_end = t_exp;
                else if (vout_low)        dis_end = vly_hit;
                else                      dis_end = zro_hit;
                if (dis_end) begin
                    if (vout_low) begin
                        cur_d.st = ST_CHARGE;
                        cur_d.md = pick_mode(mode_code, vout_up);
                    end else begin
                        cur_d.st = ST_SLEEP;
                    end
                end
            end
        endcase
        if (kill) begin
            cur_d.st = ST_SLEEP;
            t_load   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '{st: ST_SLEEP, md: MD_START};
        else        cur_q <= cur_d;
    end

    bb_tick_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_exp)
    );

    assign leg_req[0] = {req.a, req.b};
    assign leg_req[1] = {req.d, req.c};

    for (genvar g = 0; g < NLEG; g++) begin : g_leg
        bb_leg_guard #(.DEAD(DEAD_CYC)) u_guard (
            .clk   (clk),
            .rst_n (rst_n),
            .kill  (kill),
            .req   (leg_req[g]),
            .on    (leg_on[g])
        );
    end

    assign sw_a = leg_on[0][1] & ~kill;
    assign sw_b = leg_on[0][0] & ~kill;
    assign sw_d = leg_on[1][1] & ~kill;
    assign sw_c = leg_on[1][0] & ~kill;
endmodule

// File: rtl/bb_burst_seq_chk.sv
module bb_burst_seq_chk
    import bb_burst_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       shdn,
    input logic       hot,
    input logic       sw_a,
    input logic       sw_b,
    input logic       sw_c,
    input logic       sw_d,
    input seq_state_e st_q,
    input pair_mode_e md_q
);
    assert_no_shoot_ab_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(sw_a && sw_b));
    assert_no_shoot_cd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(sw_c && sw_d));

    assert_gap_d_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_d) |-> !$past(sw_c));
    assert_gap_c_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_c) |-> !$past(sw_d));
    assert_gap_a_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_a) |-> !$past(sw_b));
    assert_gap_b_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_b) |-> !$past(sw_a));

    assert_kill_open_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (shdn || hot) |-> !(sw_a || sw_b || sw_c || sw_d));

    assert_sleep_open_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SLEEP && $past(st_q == ST_SLEEP)) |-> !(sw_a || sw_b || sw_c || sw_d));

    assert_startup_no_d_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (md_q == MD_START && $past(md_q == MD_START)) |-> !sw_d);

    assert_boost_no_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (md_q == MD_BOOST && $past(md_q == MD_BOOST)) |-> !sw_b);
endmodule

bind bb_burst_seq bb_burst_seq_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .shdn  (shdn),
    .hot   (hot),
    .sw_a  (sw_a),
    .sw_b  (sw_b),
    .sw_c  (sw_c),
    .sw_d  (sw_d),
    .st_q  (cur_q.st),
    .md_q  (cur_q.md)
);

// File: tb/bb_burst_seq_test.sv
module bb_burst_seq_test;
    localparam int MHZ  = 250;
    localparam int TOFF = MHZ * 3000 / 1000;
    localparam int TSU  = MHZ * 800 / 1000;
    localparam int DEAD = 2;

    localparam logic [3:0] P_OFF = 4'b0000;
    localparam logic [3:0] P_AC  = 4'b1010;
    localparam logic [3:0] P_AD  = 4'b1001;
    localparam logic [3:0] P_BD  = 4'b0101;
    localparam logic [3:0] P_B   = 4'b0100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vout_low = 1'b0;
    logic [1:0] mode_code = 2'b00;
    logic vout_up = 1'b0;
    logic pk_hit = 1'b0;
    logic vly_hit = 1'b0;
    logic zro_hit = 1'b0;
    logic shdn = 1'b0;
    logic hot = 1'b0;
    logic sw_a, sw_b, sw_c, sw_d;

    int total = 0;
    int bad = 0;
    int ov_bad = 0;
    int gap_bad = 0;
    logic [3:0] prev_sw = 4'b0000;

    always #2 clk = ~clk;

    bb_burst_seq #(.CLK_MHZ(MHZ), .TOFF_NS(3000), .TSU_NS(800), .DEAD_CYC(DEAD)) uut (
        .clk(clk), .rst_n(rst_n), .vout_low(vout_low), .mode_code(mode_code),
        .vout_up(vout_up), .pk_hit(pk_hit), .vly_hit(vly_hit), .zro_hit(zro_hit),
        .shdn(shdn), .hot(hot), .sw_a(sw_a), .sw_b(sw_b), .sw_c(sw_c), .sw_d(sw_d)
    );

    // Leg monitor: overlap (R8) and missing gap (R9), sampled between edges.
    always @(negedge clk) begin
        if ((sw_a && sw_b) || (sw_c && sw_d)) ov_bad++;
        if ((prev_sw[3] && sw_b) || (prev_sw[2] && sw_a) ||
            (prev_sw[1] && sw_d) || (prev_sw[0] && sw_c)) gap_bad++;
        prev_sw = {sw_a, sw_b, sw_c, sw_d};
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_sw(input string rq, input logic [3:0] exp);
        logic [3:0] act;
        act = {sw_a, sw_b, sw_c, sw_d};
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: switches=%b expected=%b at %0t", rq, act, exp, $time);
        end
    endtask

    task automatic expect_int(input string rq, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: value=%0d expected=%0d", rq, act, exp);
        end
    endtask

    // 0 peak, 1 valley, 2 zero; called on a falling edge.
    task automatic pulse(input int which);
        case (which)
            0: pk_hit = 1'b1;
            1: vly_hit = 1'b1;
            default: zro_hit = 1'b1;
        endcase
        @(negedge clk);
        pk_hit = 1'b0;
        vly_hit = 1'b0;
        zro_hit = 1'b0;
    endtask

    task automatic t_reset_sleep;
        step(3);
        expect_sw("R1 reset", P_OFF);
        rst_n = 1'b1;
        step(3);
        pulse(0); pulse(1); pulse(2);
        step(3);
        expect_sw("R1 flags in sleep", P_OFF);
    endtask

    task automatic t_startup;
        int nb;
        int dseen;
        nb = 0;
        dseen = 0;
        vout_up = 1'b0;
        mode_code = 2'b10;
        vout_low = 1'b1;
        step(1);
        expect_sw("R11 no early wake", P_OFF);
        step(1);
        expect_sw("R11 wake latency R7", P_AC);
        step(3);
        pulse(1); pulse(2);
        step(2);
        expect_sw("R7 valley zero ignored in charge", P_AC);
        pulse(0);
        for (int i = 0; i < TSU + 20; i++) begin
            vly_hit = (i == 10);
            zro_hit = (i == 10);
            @(negedge clk);
            if ({sw_a, sw_b, sw_c, sw_d} == P_B) nb++;
            if (sw_d) dseen++;
        end
        vly_hit = 1'b0;
        zro_hit = 1'b0;
        expect_int("R7 B-only window", nb, TSU - DEAD);
        expect_int("R7 D stays open", dseen, 0);
        expect_sw("R7 charge repeats", P_AC);
        vout_low = 1'b0;
        pulse(0);
        step(TSU + 10);
        expect_sw("R1 back to sleep after startup", P_OFF);
    endtask

    task automatic t_boost;
        vout_up = 1'b1;
        mode_code = 2'b00;
        vout_low = 1'b1;
        step(5);
        expect_sw("R3 boost charge", P_AC);
        pulse(0); step(5);
        expect_sw("R3 boost discharge", P_AD);
        pulse(1); step(5);
        expect_sw("R3 boost repeats", P_AC);
        vout_low = 1'b0;
        pulse(0); step(5);
        expect_sw("R3 final boost discharge", P_AD);
        pulse(1); step(5);
        expect_sw("R6 valley does not end final", P_AD);
        pulse(2); step(5);
        expect_sw("R6 zero ends burst", P_OFF);
    endtask

    task automatic t_four(input logic [1:0] code);
        int nad;
        nad = 0;
        vout_up = 1'b1;
        mode_code = code;
        vout_low = 1'b1;
        step(5);
        expect_sw("R4 four-switch charge R2", P_AC);
        pulse(0);
        for (int i = 0; i < TOFF + 20; i++) begin
            @(negedge clk);
            if ({sw_a, sw_b, sw_c, sw_d} == P_AD) nad++;
        end
        expect_int("R4 timed AD window R2", nad, TOFF - DEAD);
        expect_sw("R4 BD after timer", P_BD);
        pulse(1); step(5);
        expect_sw("R4 four-switch repeats", P_AC);
        vout_low = 1'b0;
        pulse(0);
        step(TOFF + 10);
        expect_sw("R4 final BD", P_BD);
        pulse(1); step(5);
        expect_sw("R6 four-switch valley ignored", P_BD);
        pulse(2); step(5);
        expect_sw("R6 four-switch to sleep", P_OFF);
    endtask

    task automatic t_buck_hold;
        vout_up = 1'b1;
        mode_code = 2'b10;
        vout_low = 1'b1;
        step(5);
        expect_sw("R5 buck charge", P_AD);
        mode_code = 2'b00;
        step(5);
        expect_sw("R2 mode held in charge", P_AD);
        pulse(0); step(5);
        expect_sw("R5 buck discharge R2", P_BD);
        pulse(1); step(5);
        expect_sw("R2 new mode at next charge", P_AC);
        vout_low = 1'b0;
        pulse(0); step(5);
        expect_sw("R3 boost final", P_AD);
        pulse(2); step(5);
        expect_sw("R6 sleep after buck test", P_OFF);
    endtask

    task automatic t_kill;
        vout_up = 1'b1;
        mode_code = 2'b00;
        vout_low = 1'b1;
        step(5);
        expect_sw("R10 running before shutdown", P_AC);
        shdn = 1'b1;
        #1;
        expect_sw("R10 shutdown same cycle", P_OFF);
        step(10);
        expect_sw("R10 held off in shutdown", P_OFF);
        vout_up = 1'b0;
        shdn = 1'b0;
        step(8);
        expect_sw("R10 restart charge", P_AC);
        pulse(0); step(5);
        expect_sw("R10 restart uses startup", P_B);
        step(TSU);
        expect_sw("R10 startup repeats", P_AC);
        hot = 1'b1;
        #1;
        expect_sw("R10 over-temperature same cycle", P_OFF);
        step(6);
        vout_low = 1'b0;
        hot = 1'b0;
        step(6);
        expect_sw("R10 sleep after release", P_OFF);
    endtask

    initial begin
        t_reset_sleep();
        t_startup();
        t_boost();
        t_four(2'b01);
        t_four(2'b11);
        t_buck_hold();
        t_kill();
        expect_int("R8 leg overlap count", ov_bad, 0);
        expect_int("R9 dead-time gap violations", gap_bad, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule